// File: doc/BRIEF.md
# Block lock and erase sequencer

This controller holds one lock bit and one erase-status bit for each block of a 32-block nonvolatile array model. A command controller starts four kinds of operation: erase of one block, erase of the whole array, setting the lock of one block, and clearing every lock at once. The controller reports busy and two sticky error flags. An abstract array model performs each block erase. It is driven by a request and a block number, and it answers with a done pulse that carries a fail flag.

A write-protect input (active low) governs which operations are allowed. While it is active, locked blocks cannot be erased and no lock bit can change. While it is inactive, locks do not restrict anything. A whole-array erase visits the blocks in ascending order. It passes over locked blocks without complaint when write-protect is active, and it halts at the first block that fails. Lock changes take a programmable number of cycles, which stands in for cell timing. A single "voltage ok" input stands in for the programming-supply check. A per-block status byte can be read at any time through a separate block-select input.

Top module: `blk_lock_seq`

## Requirements
- R1: The array has 32 blocks, selected by a 5-bit block number. For the block on `stat_blk`, `stat_byte` shows the lock bit on bit 0 and the erase-status bit on bit 1 (1 means the last erase of that block did not complete successfully). Bits 7..2 are zero.
- R2: A single-block erase (op 0) of a locked block while `wp_n` is 0 is refused. `lock_err` and `erase_err` are both 1 after the next clock edge, `busy` never rises, and `ers_req` is not raised.
- R3: While `wp_n` is 1, a single-block erase of a locked block proceeds normally, and the block's lock bit is left set.
- R4: Set-lock (op 2) and clear-all-locks (op 3) are refused with `lock_err` when `wp_n` is 0, and the lock bits stay unchanged. When accepted, they keep `busy` high for LOCK_CYCLES cycles and then set the addressed bit or clear all 32 bits.
- R5: A whole-array erase (op 1) raises one `ers_req` per block. The requests go in ascending block order starting at block 0, and only one block is in progress at a time.
- R6: During a whole-array erase with `wp_n` 0, locked blocks get no request and `lock_err` stays 0. With `wp_n` 1, all 32 blocks are erased.
- R7: An `ers_done` pulse with `ers_fail` high sets that block's erase-status bit and sets `erase_err`. It also ends the operation: no further block gets a request.
- R8: An erase-status bit changes only when an erase of its block finishes, or when reset arrives during that block's erase (the bit becomes 1). Reset clears neither the lock bits nor the other status bits.
- R9: `busy` is high exactly while an operation runs. A start pulse seen while busy is ignored.
- R10: A start with `vpp_ok` low is refused without going busy. Erase ops set `erase_err` and lock ops set `lock_err`.
- R11: Reset clears both error flags. An accepted or refused start clears them before applying its own result. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse for the operation on `op` |
| op | input | 2 | 0 block erase, 1 whole-array erase, 2 set lock, 3 clear all locks |
| blk_addr | input | 5 | Target block for ops 0 and 2 |
| wp_n | input | 1 | Write-protect, active low |
| vpp_ok | input | 1 | Programming supply valid |
| ers_done | input | 1 | Array model: erase of `ers_blk` finished |
| ers_fail | input | 1 | Array model: that erase failed (valid with `ers_done`) |
| stat_blk | input | 5 | Block whose status byte is shown |
| busy | output | 1 | Operation running |
| lock_err | output | 1 | Sticky lock refusal flag |
| erase_err | output | 1 | Sticky erase failure or refusal flag |
| ers_req | output | 1 | Erase request to array model, held until `ers_done` |
| ers_blk | output | 5 | Block being erased |
| stat_byte | output | 8 | Status byte of `stat_blk` |

## Verification
The bench builds the sequencer with the default 32 blocks and with LOCK_CYCLES set to 3. Its array responder answers each request after three cycles. Because of these values, a complete 32-block walk, a fail injected at block 10, and a reset landing inside an open erase all fit in a few hundred cycles. This lets the reference model be compared on every clock across the whole walk, including the last-block boundary and the skips of locked blocks 5, 17 and 31.

// File: rtl/blk_lock_seq.sv
module blk_lock_seq #(
  parameter int NBLK        = 32,
  parameter int LOCK_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               op,
  input  logic [$clog2(NBLK)-1:0]  blk_addr,
  input  logic                     wp_n,
  input  logic                     vpp_ok,
  input  logic                     ers_done,
  input  logic                     ers_fail,
  input  logic [$clog2(NBLK)-1:0]  stat_blk,
  output logic                     busy,
  output logic                     lock_err,
  output logic                     erase_err,
  output logic                     ers_req,
  output logic [$clog2(NBLK)-1:0]  ers_blk,
  output logic [7:0]               stat_byte
);
  localparam int AW = $clog2(NBLK);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [AW-1:0] LAST = AW'(NBLK - 1);
  localparam logic [1:0] OP_BLK  = 2'd0;
  localparam logic [1:0] OP_CHIP = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_ERS, S_LOCK} st_t;

  st_t            st;
  logic [AW-1:0]  cur;
  logic [CW-1:0]  cnt;
  logic           chip, clr;
  logic [NBLK-1:0] lock, est;

  wire tgt_locked = lock[blk_addr] && !wp_n;
  wire cur_skip   = lock[cur] && !wp_n;

  assign busy      = (st != S_IDLE);
  assign ers_req   = (st == S_ERS);
  assign ers_blk   = cur;
  assign stat_byte = {6'b0, est[stat_blk], lock[stat_blk]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (st == S_ERS) est[cur] <= 1'b1;
      st        <= S_IDLE;
      cur       <= '0;
      cnt       <= '0;
      chip      <= 1'b0;
      clr       <= 1'b0;
      lock_err  <= 1'b0;
      erase_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          lock_err  <= 1'b0;
          erase_err <= 1'b0;
          cur       <= blk_addr;
          chip      <= 1'b0;
          clr       <= op[0];
          cnt       <= CW'(LOCK_CYCLES - 1);
          case (op)
            OP_BLK: begin
              if (!vpp_ok) erase_err <= 1'b1;
              else if (tgt_locked) begin
                lock_err  <= 1'b1;
                erase_err <= 1'b1;
              end else st <= S_ERS;
            end
            OP_CHIP: begin
              if (!vpp_ok) erase_err <= 1'b1;
              else begin
                st   <= S_SCAN;
                cur  <= '0;
                chip <= 1'b1;
              end
            end
            default: begin
              if (!vpp_ok || !wp_n) lock_err <= 1'b1;
              else st <= S_LOCK;
            end
          endcase
        end
        S_SCAN: begin
          if (cur_skip) begin
            if (cur == LAST) st <= S_IDLE;
            else cur <= cur + 1'b1;
          end else st <= S_ERS;
        end
        S_ERS: if (ers_done) begin
          est[cur] <= ers_fail;
          if (ers_fail) begin
            erase_err <= 1'b1;
            st        <= S_IDLE;
          end else if (chip && cur != LAST) begin
            cur <= cur + 1'b1;
            st  <= S_SCAN;
          end else st <= S_IDLE;
        end
        S_LOCK: begin
          if (cnt == '0) begin
            if (clr) lock <= '0;
            else lock[cur] <= 1'b1;
            st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REFUSE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == OP_BLK && vpp_ok && tgt_locked) |=> (!busy && lock_err && erase_err)); // R2
  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_LOCK) |=> $stable(lock)); // R4
  AST_WALK_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN) |=> (!busy || cur == $past(cur) || cur == AW'($past(cur) + 1'b1))); // R5
  AST_SCAN_NO_LOCKERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN) |=> !lock_err); // R6
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_req && ers_done && ers_fail) |=> (!busy && erase_err && stat_byte[1] == (stat_blk == $past(cur) ? 1'b1 : stat_byte[1]))); // R7
  AST_HOLD_WHILE_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_req && !ers_done) |=> (ers_req && $stable(ers_blk))); // R9
endmodule

// File: tb/blk_lock_seq_test.sv
module blk_lock_seq_test;
  localparam int LOCKC = 3;
  localparam int LAT   = 3;

  logic       clk = 0, rst_n = 0, start = 0, wp_n = 1, vpp_ok = 1;
  logic       ers_done = 0, ers_fail = 0;
  logic [1:0] op = 0;
  logic [4:0] blk_addr = 0, stat_blk = 0;
  logic       busy, lock_err, erase_err, ers_req;
  logic [4:0] ers_blk;
  logic [7:0] stat_byte;

  blk_lock_seq #(.NBLK(32), .LOCK_CYCLES(LOCKC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .blk_addr(blk_addr),
    .wp_n(wp_n), .vpp_ok(vpp_ok), .ers_done(ers_done), .ers_fail(ers_fail),
    .stat_blk(stat_blk), .busy(busy), .lock_err(lock_err), .erase_err(erase_err),
    .ers_req(ers_req), .ers_blk(ers_blk), .stat_byte(stat_byte));

  always #2 clk = ~clk;

  int vectors = 0, miscmp = 0, cycles = 0, fail_blk = -1, rq_cnt = 0;
  bit live = 0, done_flag = 0;

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model
  bit [31:0] m_lock, m_lkn, m_est, m_ekn;
  int  m_st = 0, m_cur = 0, m_cnt = 0;
  bit  m_chip, m_clr, m_le, m_ee;

  always @(posedge clk) begin
    if (!rst_n) begin
      if (m_st == 2) begin m_est[m_cur] = 1; m_ekn[m_cur] = 1; end
      m_st = 0; m_cur = 0; m_le = 0; m_ee = 0; m_chip = 0;
    end else if (m_st == 0) begin
      if (start) begin
        m_le = 0; m_ee = 0;
        if (op == 0) begin
          if (!vpp_ok) m_ee = 1;
          else if (!wp_n && m_lock[blk_addr]) begin m_le = 1; m_ee = 1; end
          else begin m_st = 2; m_cur = blk_addr; m_chip = 0; end
        end else if (op == 1) begin
          if (!vpp_ok) m_ee = 1;
          else begin m_st = 1; m_cur = 0; m_chip = 1; end
        end else begin
          if (!vpp_ok || !wp_n) m_le = 1;
          else begin m_st = 3; m_cnt = LOCKC; m_cur = blk_addr; m_clr = op[0]; end
        end
      end
    end else if (m_st == 1) begin
      if (!wp_n && m_lock[m_cur]) begin
        if (m_cur == 31) m_st = 0; else m_cur++;
      end else m_st = 2;
    end else if (m_st == 2) begin
      if (ers_done) begin
        m_est[m_cur] = ers_fail; m_ekn[m_cur] = 1;
        if (ers_fail) begin m_ee = 1; m_st = 0; end
        else if (m_chip && m_cur < 31) begin m_cur++; m_st = 1; end
        else m_st = 0;
      end
    end else begin
      m_cnt--;
      if (m_cnt == 0) begin
        if (m_clr) begin m_lock = 0; m_lkn = '1; end
        else begin m_lock[m_cur] = 1; m_lkn[m_cur] = 1; end
        m_st = 0;
      end
    end
  end

  // array responder and per-clock comparison
  bit rsp_on = 0; int rsp_n = 0;
  always @(negedge clk) begin
    ers_done = 0; ers_fail = 0;
    if (ers_req && !rsp_on) begin rsp_on = 1; rsp_n = LAT; rq_cnt++; end
    else if (rsp_on) begin
      rsp_n--;
      if (rsp_n == 0) begin
        ers_done = 1; ers_fail = (int'(ers_blk) == fail_blk); rsp_on = 0;
      end
    end
    if (live) begin
      cmp("R9 busy", busy, m_st != 0);
      cmp("R11 lock_err", lock_err, m_le);
      cmp("R11 erase_err", erase_err, m_ee);
      cmp("R5 ers_req", ers_req, m_st == 2);
      if (m_st == 2) cmp("R5 ers_blk", ers_blk, m_cur);
      if (m_lkn[stat_blk] && m_ekn[stat_blk])
        cmp("R1 stat_byte", stat_byte, {30'b0, m_est[stat_blk], m_lock[stat_blk]});
    end
  end

  task automatic issue(int o, int b);
    @(negedge clk); op = 2'(o); blk_addr = 5'(b); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stat(int b, int exp, string tag);
    @(negedge clk); stat_blk = 5'(b); #1;
    cmp(tag, stat_byte, exp);
  endtask

  initial begin
    while (!done_flag) begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        miscmp++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; live = 1;
    cmp("R11 reset busy", busy, 0);
    cmp("R11 reset flags", {lock_err, erase_err}, 0);
    issue(3, 0); wait_idle();
    issue(1, 0); wait_idle();
    cmp("R6 all 32 erased with wp inactive", rq_cnt, 32);
    for (int b = 0; b < 32; b += 7) stat(b, 0, "R1 clean block");

    issue(2, 5); wait_idle(); issue(2, 17); wait_idle(); issue(2, 31); wait_idle();
    stat(17, 1, "R4 set lock 17"); stat(16, 0, "R1 neighbour 16");

    wp_n = 0;
    issue(2, 3); wait_idle();
    cmp("R4 set refused", lock_err, 1); stat(3, 0, "R4 lock 3 unchanged");
    issue(3, 0); wait_idle();
    stat(5, 1, "R4 clear refused");

    rq_cnt = 0;
    issue(0, 5); wait_idle();
    cmp("R2 refused flags", {lock_err, erase_err}, 3);
    cmp("R2 no request", rq_cnt, 0);

    wp_n = 1; rq_cnt = 0;
    issue(0, 17); wait_idle();
    cmp("R3 erased locked block", rq_cnt, 1);
    stat(17, 1, "R3 lock kept, status ok");

    wp_n = 0; rq_cnt = 0;
    issue(1, 0); wait_idle();
    cmp("R6 locked skipped", rq_cnt, 29);
    cmp("R6 no lock_err", lock_err, 0);

    wp_n = 1; fail_blk = 10; rq_cnt = 0;
    issue(1, 0); wait_idle();
    cmp("R7 stopped at 10", rq_cnt, 11);
    cmp("R7 erase_err", erase_err, 1);
    stat(10, 2, "R7 status set"); stat(11, 0, "R8 block 11 untouched");
    fail_blk = -1;

    rq_cnt = 0;
    issue(0, 2);
    issue(1, 0);
    wait_idle();
    cmp("R9 start ignored while busy", rq_cnt, 1);

    vpp_ok = 0;
    issue(0, 4); wait_idle(); cmp("R10 erase vpp", {lock_err, erase_err}, 1);
    issue(2, 4); wait_idle(); cmp("R10 lock vpp", {lock_err, erase_err}, 2);
    vpp_ok = 1;
    issue(0, 4); wait_idle(); cmp("R11 flags cleared", {lock_err, erase_err}, 0);

    issue(0, 20); @(negedge clk);
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    repeat (6) @(negedge clk);
    stat(20, 2, "R8 reset abort status");
    stat(17, 1, "R8 lock survives reset");
    stat(10, 2, "R8 other status kept");

    issue(3, 0); wait_idle();
    stat(31, 0, "R4 clear all");
    stat(5, 0, "R4 clear all 5");

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule